// File: doc/BRIEF.md
# SMBus Control-Register Target

This block lets a host on a two-wire SMBus/I2C bus read and write a bank of 22 eight-bit control registers. SCL and SDA are sampled with the chip clock through two-flop synchronisers. The block finds START and STOP conditions and the SCL edges, and answers at 7-bit address 0x69. That address is 0xD2 as a write address byte and 0xD3 as a read address byte. The block pulls SDA low through an open-drain enable and never drives it high. It does not stretch the clock.

The first byte after a write address is the command byte, and it selects one of two modes. A command of 0x00 selects block mode. In block mode a write carries a byte count followed by data for registers 0, 1, 2 and so on. A read after a repeated START returns the count 22 and then every register in index order. Commands 0x01 to 0x16 select byte mode, where command k+1 addresses register k.

The rest of the chip sees every stored register in parallel, along with a one-cycle write strobe. Register 7 holds a fixed identifier and cannot be written. While an external down-count is running, register 20 reads back the live count value instead of the value stored in it.

Top module: `smb_regbank`

## Requirements
- R1: Address byte 0xD2 or 0xD3 (7-bit 0x69, bit 0 = read) is ACKed. Any other address byte is NACKed, and no byte after it is ACKed or has any effect until the next START.
- R2: Byte write: command k+1 with k from 0 to 21 is ACKed, and the next data byte is stored in register k. Further data bytes in the same transfer are ACKed and dropped.
- R3: Byte read: command k+1, then a repeated START with the read address, returns register k, then k+1 and onward. A read past register 21 returns 0xFF.
- R4: Block write: command 0x00 is followed by a count byte N and data bytes that land in registers 0 to N-1. Bytes beyond N, or beyond register 21, are ACKed and dropped.
- R5: Block read: command 0x00, then a repeated START with the read address, returns the count 0x16 (22) first and then registers 0 through 21 in order.
- R6: A command byte above 0x16 is NACKed, and the transfer has no further effect.
- R7: Register 7 always reads 0x22 on both the parallel output and the bus. Host writes to it leave it unchanged.
- R8: After reset the registers hold 0x10, 0xE7, 0x02, 0xD0, 0x7A, 0x0B, 0x0F, 0xE4, 0x88 and 0x4B at indices 0, 1, 5, 8, 9, 11, 13, 16, 20 and 21. Register 7 holds 0x22 and every other register holds 0x00.
- R9: While live_active is high, a bus read of register 20 returns live_value. Otherwise it returns the stored value.
- R10: sda_oe starts pulling low only while the synchronised SCL is low. It is released after a STOP and whenever the target is idle.
- R11: Each accepted data byte aimed at an existing register raises wr_stb for one cycle with that index and byte. reg_q[8k+7:8k] reflects register k one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| live_active | input | 1 | A down-count is in progress |
| live_value | input | 8 | Present down-count value |
| reg_q | output | 176 | All stored registers, register k in bits 8k+7:8k |
| wr_stb | output | 1 | One-cycle pulse per accepted data byte |
| wr_idx | output | 5 | Register index of the pulse |
| wr_data | output | 8 | Byte written with the pulse |

## Verification
The properties assume the bus is slow next to the chip clock. Every SCL and SDA level must last several clock cycles. SDA may change while SCL is high only to form a START or STOP. The bench's bus model holds each level for five clocks. It changes SDA only in the middle of the SCL low phase, except for the START, repeated START and STOP sequences. It resolves the wired-AND line itself from its own drive and sda_oe.

// File: rtl/smb_regbank_pkg.sv
`timescale 1ns/1ps
package smb_regbank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } smb_state_e;

  typedef enum logic [1:0] {PH_CMD, PH_COUNT, PH_DATA} wr_phase_e;

  function automatic logic [7:0] reg_reset_value(input int unsigned idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'hE7;
      5:       return 8'h02;
      8:       return 8'hD0;
      9:       return 8'h7A;
      11:      return 8'h0B;
      13:      return 8'h0F;
      16:      return 8'hE4;
      20:      return 8'h88;
      21:      return 8'h4B;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic addr_hit(input logic [7:0] addr_byte, input logic [6:0] dev);
    return addr_byte[7:1] == dev;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
`timescale 1ns/1ps
module smb_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[0], scl_in};
      sda_ff <= {sda_ff[0], sda_in};
      scl_d  <= scl_ff[1];
      sda_d  <= sda_ff[1];
    end
  end

  assign scl_q     = scl_ff[1];
  assign sda_q     = sda_ff[1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_evt = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_evt  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/smb_regfile.sv
`timescale 1ns/1ps
module smb_regfile #(
  parameter int          NREG     = 22,
  parameter int          IDX_W    = 5,
  parameter int          ID_IDX   = 7,
  parameter logic [7:0]  ID_VAL   = 8'h22,
  parameter int          LIVE_IDX = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic                 live_active,
  input  logic [7:0]           live_value,
  output logic [7:0]           rd_data,
  output logic [NREG*8-1:0]    reg_flat
);
  import smb_regbank_pkg::*;

  logic [7:0] stored [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        stored[i] <= (i == ID_IDX) ? ID_VAL : reg_reset_value(i);
    end else if (wr_stb) begin
      for (int i = 0; i < NREG; i++)
        if (wr_idx == IDX_W'(i) && i != ID_IDX) stored[i] <= wr_data;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign reg_flat[g*8 +: 8] = stored[g];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDX_W'(i)) rd_data = stored[i];
    if (live_active && rd_idx == IDX_W'(LIVE_IDX)) rd_data = live_value;
  end
endmodule

// File: rtl/smb_link_fsm.sv
`timescale 1ns/1ps
module smb_link_fsm #(
  parameter int         NREG     = 22,
  parameter int         IDX_W    = 5,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_stb,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             addr_evt,
  output logic             addr_match,
  output logic             cmd_evt,
  output logic             cmd_bad
);
  import smb_regbank_pkg::*;

  localparam logic [IDX_W-1:0] END_PTR = IDX_W'(NREG);
  localparam logic [7:0]       NREG_B  = 8'(NREG);

  smb_state_e       state;
  wr_phase_e        phase;
  logic [2:0]       bitcnt;
  logic             byte_rdy, rw, block_mode, cnt_pending, mack;
  logic [7:0]       shreg, txreg, remain;
  logic [IDX_W-1:0] ptr;

  logic       quiet, byte_end, tx_load, send_count;
  logic [7:0] tx_pick;

  function automatic logic [IDX_W-1:0] ptr_advance(input logic [IDX_W-1:0] p);
    return (p == END_PTR) ? p : p + IDX_W'(1);
  endfunction

  assign quiet      = !start_evt && !stop_evt;
  assign byte_end   = quiet && scl_fall && byte_rdy;
  assign addr_evt   = (state == ST_ADDR) && byte_end;
  assign addr_match = addr_hit(shreg, DEV_ADDR);
  assign cmd_evt    = (state == ST_WR) && (phase == PH_CMD) && byte_end;
  assign cmd_bad    = shreg > NREG_B;
  assign send_count = block_mode && cnt_pending;
  assign tx_pick    = send_count ? NREG_B : rd_data;
  assign tx_load    = quiet && scl_fall &&
                      (((state == ST_ADDR_ACK) && rw) || ((state == ST_RD_ACK) && mack));
  assign rd_idx     = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  phase <= PH_CMD;  bitcnt <= '0;  byte_rdy <= 1'b0;
      rw <= 1'b0;  block_mode <= 1'b0;  cnt_pending <= 1'b0;  mack <= 1'b0;
      shreg <= '0;  txreg <= '0;  remain <= '0;  ptr <= '0;  sda_oe <= 1'b0;
      wr_stb <= 1'b0;  wr_idx <= '0;  wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state <= ST_ADDR;  bitcnt <= '0;  byte_rdy <= 1'b0;  sda_oe <= 1'b0;
      end else if (stop_evt) begin
        state <= ST_IDLE;  byte_rdy <= 1'b0;  sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_q};
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) byte_rdy <= 1'b1;
            end else if (byte_end) begin
              byte_rdy <= 1'b0;
              if (state == ST_ADDR) begin
                if (addr_match) begin
                  rw <= shreg[0];  sda_oe <= 1'b1;  state <= ST_ADDR_ACK;
                  if (!shreg[0]) phase <= PH_CMD;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;  state <= ST_WR_ACK;
                case (phase)
                  PH_CMD: begin
                    if (shreg == 8'h00) begin
                      block_mode <= 1'b1;  cnt_pending <= 1'b1;  ptr <= '0;  phase <= PH_COUNT;
                    end else if (!cmd_bad) begin
                      block_mode <= 1'b0;  ptr <= IDX_W'(shreg - 8'd1);  remain <= 8'd1;
                      phase <= PH_DATA;
                    end else begin
                      sda_oe <= 1'b0;  state <= ST_IDLE;
                    end
                  end
                  PH_COUNT: begin
                    remain <= shreg;  phase <= PH_DATA;
                  end
                  default: begin
                    if (remain != 8'd0) begin
                      remain <= remain - 8'd1;
                      ptr    <= ptr_advance(ptr);
                      if (ptr < END_PTR) begin
                        wr_stb <= 1'b1;  wr_idx <= ptr;  wr_data <= shreg;
                      end
                    end
                  end
                endcase
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;  bitcnt <= '0;
            state  <= rw ? ST_RD : ST_WR;
          end
          ST_WR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;  bitcnt <= '0;  state <= ST_WR;
          end
          ST_RD: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe <= 1'b0;  state <= ST_RD_ACK;
            end else begin
              sda_oe <= ~txreg[6];  txreg <= {txreg[6:0], 1'b0};  bitcnt <= bitcnt + 3'd1;
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) mack <= ~sda_q;
            else if (scl_fall) state <= mack ? ST_RD : ST_IDLE;
          end
          default: ;
        endcase
        if (tx_load) begin
          txreg  <= tx_pick;
          sda_oe <= ~tx_pick[7];
          bitcnt <= '0;
          if (send_count) cnt_pending <= 1'b0;
          else            ptr <= ptr_advance(ptr);
        end
      end
    end
  end
endmodule

// File: rtl/smb_regbank.sv
`timescale 1ns/1ps
module smb_regbank #(
  parameter int         NUM_REGS = 22,
  parameter int         IDX_W    = $clog2(NUM_REGS + 1),
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         ID_IDX   = 7,
  parameter logic [7:0] ID_VAL   = 8'h22,
  parameter int         LIVE_IDX = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_in,
  input  logic                    sda_in,
  output logic                    sda_oe,
  input  logic                    live_active,
  input  logic [7:0]              live_value,
  output logic [NUM_REGS*8-1:0]   reg_q,
  output logic                    wr_stb,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [7:0]              wr_data
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_evt, stop_evt;
  logic addr_evt, addr_match, cmd_evt, cmd_bad;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_data;

  smb_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_link_fsm #(.NREG(NUM_REGS), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(rd_data), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
    .addr_evt(addr_evt), .addr_match(addr_match), .cmd_evt(cmd_evt), .cmd_bad(cmd_bad)
  );

  smb_regfile #(.NREG(NUM_REGS), .IDX_W(IDX_W), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL),
                .LIVE_IDX(LIVE_IDX)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .live_active(live_active), .live_value(live_value),
    .rd_data(rd_data), .reg_flat(reg_q)
  );
endmodule

// File: rtl/smb_regbank_chk.sv
`timescale 1ns/1ps
module smb_regbank_chk #(
  parameter int         NREG   = 22,
  parameter int         IDX_W  = 5,
  parameter int         ID_IDX = 7,
  parameter logic [7:0] ID_VAL = 8'h22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_q,
  input logic              stop_evt,
  input logic              sda_oe,
  input logic              addr_evt,
  input logic              addr_match,
  input logic              cmd_evt,
  input logic              cmd_bad,
  input logic              wr_stb,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [7:0]        wr_data,
  input logic [NREG*8-1:0] reg_flat
);
  function automatic logic [7:0] byte_at(input logic [NREG*8-1:0] f, input logic [IDX_W-1:0] i);
    logic [7:0] v;
    v = 8'h00;
    for (int k = 0; k < NREG; k++) if (i == IDX_W'(k)) v = f[k*8 +: 8];
    return v;
  endfunction

  a_r1_nack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    addr_evt && !addr_match |=> !sda_oe) else $error("foreign address acknowledged");

  a_r1_ack_own: assert property (@(posedge clk) disable iff (!rst_n)
    addr_evt && addr_match |=> sda_oe) else $error("own address not acknowledged");

  a_r6_nack_bad_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_evt && cmd_bad |=> !sda_oe) else $error("bad command acknowledged");

  a_r10_pull_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q) else $error("SDA pulled while SCL high");

  a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe) else $error("SDA held after STOP");

  a_r11_strobe_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_idx < IDX_W'(NREG)) else $error("strobe index out of range");

  a_r11_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_idx != IDX_W'(ID_IDX) |=> byte_at(reg_flat, $past(wr_idx)) == $past(wr_data))
    else $error("strobed byte not stored");

  a_r7_id_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb && wr_idx == IDX_W'(ID_IDX) |=> byte_at(reg_flat, IDX_W'(ID_IDX)) == ID_VAL)
    else $error("identifier overwritten");
endmodule

bind smb_regbank smb_regbank_chk #(.NREG(NUM_REGS), .IDX_W(IDX_W), .ID_IDX(ID_IDX),
                                   .ID_VAL(ID_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .stop_evt(stop_evt), .sda_oe(sda_oe),
  .addr_evt(addr_evt), .addr_match(addr_match), .cmd_evt(cmd_evt), .cmd_bad(cmd_bad),
  .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data), .reg_flat(reg_q)
);

// File: tb/smb_regbank_tb.sv
`timescale 1ns/1ps
module smb_regbank_tb;
  localparam int N = 22;
  localparam int T = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_line, sda_oe, live_on, wr_stb;
  logic [7:0] live_val, wr_data;
  logic [4:0] wr_idx;
  logic [N*8-1:0] reg_q;

  assign sda_line = sda_m & ~sda_oe;

  smb_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
    .live_active(live_on), .live_value(live_val), .reg_q(reg_q),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  int unsigned n_chk = 0, n_bad = 0, stb_cnt = 0;
  logic [4:0] last_idx = '0;
  logic [7:0] last_data = '0;
  logic [7:0] mdl [N];

  always @(posedge clk) if (wr_stb) begin
    stb_cnt++;
    last_idx  = wr_idx;
    last_data = wr_data;
  end

  function automatic logic [7:0] dflt(input int k);
    case (k)
      0: return 8'h10;  1: return 8'hE7;  5: return 8'h02;  7: return 8'h22;
      8: return 8'hD0;  9: return 8'h7A;  11: return 8'h0B; 13: return 8'h0F;
      16: return 8'hE4; 20: return 8'h88; 21: return 8'h4B;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_rd(input int k);
    if (k >= N) return 8'hFF;
    if (k == 20 && live_on) return live_val;
    return mdl[k];
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < N; k++) chk8(tag, reg_q[k*8 +: 8], mdl[k]);
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; hold(T); scl_m = 1'b1; hold(T); scl_m = 1'b0; hold(T);
  endtask

  task automatic bit_r(output logic v);
    sda_m = 1'b1; hold(T); scl_m = 1'b1; hold(T); v = sda_line; scl_m = 1'b0; hold(T);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) bit_w(b[i]);
    bit_r(v);
    ack = ~v;
  endtask

  task automatic rd_byte(output logic [7:0] b, input logic give_ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin bit_r(v); b[i] = v; end
    bit_w(~give_ack);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; hold(T); scl_m = 1'b0; hold(T);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; hold(T); scl_m = 1'b1; hold(T); sda_m = 1'b0; hold(T); scl_m = 1'b0; hold(T);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(T); scl_m = 1'b1; hold(T); sda_m = 1'b1; hold(T);
    chk8("R10 release after stop", 8'(sda_oe), 8'd0);
  endtask

  task automatic byte_write(input int idx, input logic [7:0] val, input int extra);
    logic a; int unsigned s0;
    bus_start();
    wr_byte(8'hD2, a);        chk8("R1 write address ack", 8'(a), 8'd1);
    wr_byte(8'(idx + 1), a);  chk8("R2 command ack", 8'(a), 8'd1);
    s0 = stb_cnt;
    wr_byte(val, a);          chk8("R2 data ack", 8'(a), 8'd1);
    for (int e = 0; e < extra; e++) begin
      wr_byte(8'hC3, a);      chk8("R2 extra byte ack", 8'(a), 8'd1);
    end
    bus_stop();
    chk8("R11 strobe count", 8'(stb_cnt - s0), 8'd1);
    chk8("R11 strobe index", 8'(last_idx), 8'(idx));
    chk8("R11 strobe data", last_data, val);
    if (idx != 7) mdl[idx] = val;
    check_all("R2 stored registers");
  endtask

  task automatic byte_read(input int idx, input int nbytes);
    logic a; logic [7:0] v;
    bus_start();
    wr_byte(8'hD2, a);        chk8("R1 write address ack", 8'(a), 8'd1);
    wr_byte(8'(idx + 1), a);  chk8("R3 command ack", 8'(a), 8'd1);
    bus_rstart();
    wr_byte(8'hD3, a);        chk8("R1 read address ack", 8'(a), 8'd1);
    for (int j = 0; j < nbytes; j++) begin
      rd_byte(v, j < nbytes - 1);
      chk8((idx + j == 20) ? "R9 register 20 read" : "R3 byte read data", v, exp_rd(idx + j));
    end
    bus_stop();
  endtask

  task automatic block_write(input int cnt, input int extra);
    logic a; logic [7:0] d;
    bus_start();
    wr_byte(8'hD2, a);     chk8("R1 write address ack", 8'(a), 8'd1);
    wr_byte(8'h00, a);     chk8("R4 block command ack", 8'(a), 8'd1);
    wr_byte(8'(cnt), a);   chk8("R4 count ack", 8'(a), 8'd1);
    for (int i = 0; i < cnt + extra; i++) begin
      d = 8'($urandom);
      wr_byte(d, a);       chk8("R4 block data ack", 8'(a), 8'd1);
      if (i < cnt && i < N && i != 7) mdl[i] = d;
    end
    bus_stop();
    check_all("R4 block write result");
  endtask

  task automatic block_read();
    logic a; logic [7:0] v;
    bus_start();
    wr_byte(8'hD2, a);     chk8("R1 write address ack", 8'(a), 8'd1);
    wr_byte(8'h00, a);     chk8("R5 block command ack", 8'(a), 8'd1);
    bus_rstart();
    wr_byte(8'hD3, a);     chk8("R1 read address ack", 8'(a), 8'd1);
    rd_byte(v, 1'b1);      chk8("R5 block count", v, 8'd22);
    for (int i = 0; i < N; i++) begin
      rd_byte(v, i < N - 1);
      chk8("R5 block read data", v, exp_rd(i));
    end
    bus_stop();
  endtask

  task automatic foreign_addr(input logic [7:0] ab);
    logic a;
    bus_start();
    wr_byte(ab, a);        chk8("R1 foreign address nack", 8'(a), 8'd0);
    wr_byte(8'h01, a);     chk8("R1 ignored after nack", 8'(a), 8'd0);
    wr_byte(8'h5C, a);     chk8("R1 ignored after nack", 8'(a), 8'd0);
    bus_stop();
    check_all("R1 no effect");
  endtask

  task automatic bad_cmd(input logic [7:0] c);
    logic a;
    bus_start();
    wr_byte(8'hD2, a);     chk8("R1 write address ack", 8'(a), 8'd1);
    wr_byte(c, a);         chk8("R6 bad command nack", 8'(a), 8'd0);
    wr_byte(8'h66, a);     chk8("R6 ignored after nack", 8'(a), 8'd0);
    bus_stop();
    check_all("R6 no effect");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd4242);
    live_on = 1'b0;
    live_val = 8'h00;
    for (int k = 0; k < N; k++) mdl[k] = dflt(k);
    hold(4);
    rst_n = 1'b1;
    hold(4);

    check_all("R8 reset defaults");
    chk8("R7 identifier at reset", reg_q[7*8 +: 8], 8'h22);
    chk8("R10 idle release", 8'(sda_oe), 8'd0);

    byte_write(3, 8'h5A, 0);
    byte_read(3, 1);
    byte_write(4, 8'h11, 1);
    byte_write(7, 8'h99, 0);
    chk8("R7 identifier kept", reg_q[7*8 +: 8], 8'h22);
    byte_read(7, 1);
    byte_write(21, 8'hA5, 0);
    byte_read(21, 2);
    foreign_addr(8'hA4);
    foreign_addr(8'hD0);
    bad_cmd(8'h17);
    bad_cmd(8'h30);
    block_write(24, 1);
    block_read();
    block_write(3, 2);
    live_on = 1'b1;
    live_val = 8'h37;
    byte_read(20, 1);
    byte_read(19, 2);
    block_read();
    live_on = 1'b0;
    byte_read(20, 1);

    for (int it = 0; it < 20; it++) begin
      r = $urandom;
      live_on  = r[8];
      live_val = 8'($urandom);
      case (r % 8)
        0, 1, 2: byte_write(int'($urandom % N), 8'($urandom), int'(r[4]));
        3, 4, 5: byte_read(int'($urandom % N), 1 + int'(r[5]));
        6:       block_write(1 + int'($urandom % 24), int'(r[6]));
        default: block_read();
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule